// File: doc/BRIEF.md
# Variable-Latency Bus Subordinate with Register Storage

This block is a memory-mapped subordinate on a single-manager pipelined system bus of the AHB-Lite kind. It holds a small word-addressed register array and answers reads and writes to it. It stretches each transfer's data phase by holding its ready output low for a number of cycles. That count is chosen per transfer from the address region and from an internal busy condition. Each low cycle is one wait state, so a data phase always lasts the wait count plus one cycles.

The address space is split into four regions by the two top address bits. Two regions answer immediately. One always costs a fixed latency. One costs a short latency normally and a longer one when the previous completed transfer was a write. Read data appears only in the cycle that completes the transfer. Write data is taken only in that same cycle, so a manager that changes its write data during the waits still stores the value it presents at completion. The response is always OKAY.

Top module: `waitstate_sub`

## Requirements
- R1: After a synchronous active-high reset, bus_ready_out is 1, bus_rdata is 0 and bus_resp is 0.
- R2: While no transfer is accepted, bus_ready_out stays 1. An IDLE (bus_trans=0) or BUSY (bus_trans=1) cycle gets a zero-wait OKAY and changes no storage.
- R3: An address phase is accepted only when bus_sel=1, bus_trans is NONSEQ (2) or SEQ (3), and bus_ready=1. A write offered with bus_ready=0 or bus_sel=0 leaves storage unchanged and does not stall.
- R4: Regions 0 and 3 (bus_addr[11:10]) complete with zero waits: bus_ready_out is 1 in the first data cycle and read data is valid there.
- R5: Region 1 holds bus_ready_out low for exactly 3 cycles before completing.
- R6: Region 2 holds bus_ready_out low for 4 cycles if the previous completed transfer was a write, and for 1 cycle otherwise. This includes a write that completes in the same cycle as the new address phase.
- R7: bus_rdata is 0 in every cycle where bus_ready_out is 0, and on the completing cycle of a write. It carries the stored word only on the completing cycle of a read.
- R8: Write data is captured from bus_wdata only in the completing cycle. Values driven during wait cycles are never stored.
- R9: bus_size selects byte (0), halfword (1) or word (2 or more) writes. The written lanes are those inside the size-aligned block that holds bus_addr[1:0]. Lane n is bus_wdata[8n+7:8n].
- R10: A zero-wait read whose address phase coincides with the completing cycle of a write to the same word returns the newly written bytes.
- R11: bus_resp is 0 (OKAY) in every cycle.
- R12: No transfer holds bus_ready_out low for more than 4 consecutive cycles.
- R13: Storage is indexed by {bus_addr[11:10], bus_addr[5:2]}, so each region owns 16 distinct words and bus_addr[9:6] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Subordinate select from the address decoder |
| bus_addr | input | 12 | Byte address of the address phase |
| bus_trans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, valid in the data phase |
| bus_ready | input | 1 | Bus-wide ready seen by all participants |
| bus_ready_out | output | 1 | This subordinate's ready, low during wait states |
| bus_rdata | output | 32 | Read data, nonzero only on a read's completing cycle |
| bus_resp | output | 1 | Response, always 0 (OKAY) |

## Verification
The bench checks the exact wait count of every transfer in every region. It catches an off-by-one counter, which would complete a cycle early or late, and a variable region that ignores, or looks one transfer too late at, the write that just completed. It scrambles write data during every wait cycle and counts on reads returning the completing-cycle value, so a design that latches write data at the first data cycle stores garbage. Directed cases offer writes with bus_ready low, with the subordinate deselected and as BUSY cycles, then read the word back. They also issue a read of a just-written word in the completing cycle of that write; a missing bypass returns stale data there.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  typedef enum logic [1:0] {
    RG_FAST  = 2'd0,
    RG_FIXED = 2'd1,
    RG_VAR   = 2'd2,
    RG_SPARE = 2'd3
  } region_e;

  localparam logic RESP_OKAY = 1'b0;
endpackage

// File: rtl/ws_latency.sv
`timescale 1ns/1ps
// Picks the number of wait states for a new transfer from its region and
// the busy condition that will hold after the current edge.
module ws_latency #(
  parameter int W_FAST      = 0,
  parameter int W_FIXED     = 3,
  parameter int W_VAR_SHORT = 1,
  parameter int W_VAR_LONG  = 4,
  parameter int CNT_W       = 3
) (
  input  ws_pkg::region_e   region,
  input  logic              busy,
  output logic [CNT_W-1:0]  waits
);
  import ws_pkg::*;

  always_comb begin
    unique case (region)
      RG_FIXED: waits = CNT_W'(W_FIXED);
      RG_VAR:   waits = busy ? CNT_W'(W_VAR_LONG) : CNT_W'(W_VAR_SHORT);
      default:  waits = CNT_W'(W_FAST);
    endcase
  end
endmodule

// File: rtl/ws_lane_mask.sv
`timescale 1ns/1ps
// Byte-lane enables: a lane is written when it falls in the same
// size-aligned block as the transfer's low address bits.
module ws_lane_mask #(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       size,
  output logic [LANES-1:0] mask
);
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      mask[l] = (32'(size) >= OFF_W) ||
                ((OFF_W'(l) >> size) == (off >> size));
    end
  end
endmodule

// File: rtl/ws_store.sv
`timescale 1ns/1ps
// One byte-wide array per lane with synchronous write and registered read,
// shaped for block RAM. The read register bypasses a same-edge write and
// clears to zero whenever no read completes.
module ws_store #(
  parameter int LANES = 4,
  parameter int IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [LANES-1:0]     wmask,
  input  logic [LANES*8-1:0]   wdata,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     ridx,
  output logic [LANES*8-1:0]   rdata
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rq;
    logic       fwd;

    assign fwd = we && wmask[g] && (widx == ridx);

    always_ff @(posedge clk) begin
      if (we && wmask[g]) mem[widx] <= wdata[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst)         rq <= '0;
      else if (!rd_en) rq <= '0;
      else if (fwd)    rq <= wdata[g*8 +: 8];
      else             rq <= mem[ridx];
    end

    assign rdata[g*8 +: 8] = rq;
  end
endmodule

// File: rtl/waitstate_sub.sv
`timescale 1ns/1ps
module waitstate_sub #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int WORD_BITS   = 4,
  parameter int W_FAST      = 0,
  parameter int W_FIXED     = 3,
  parameter int W_VAR_SHORT = 1,
  parameter int W_VAR_LONG  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_trans,
  input  logic              bus_write,
  input  logic [2:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  output logic              bus_ready_out,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_resp
);
  import ws_pkg::*;

  localparam int LANES    = DATA_W / 8;
  localparam int OFF_W    = $clog2(LANES);
  localparam int IDX_W    = 2 + WORD_BITS;
  localparam int MAX_A    = (W_FAST > W_FIXED) ? W_FAST : W_FIXED;
  localparam int MAX_B    = (W_VAR_SHORT > W_VAR_LONG) ? W_VAR_SHORT : W_VAR_LONG;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

  // data-phase state
  logic             dphase_q;
  logic             ready_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             wr_q;
  logic [IDX_W-1:0] idx_q;
  logic [LANES-1:0] mask_q;

  // address-phase decode
  region_e          new_region;
  logic [IDX_W-1:0] new_idx;
  logic [CNT_W-1:0] new_waits;
  logic [LANES-1:0] new_mask;

  logic waiting, complete, start, busy_next, last_wait;
  logic st_we, st_rd;
  logic [IDX_W-1:0] st_ridx;
  logic unused_bits;

  assign new_region = region_e'(bus_addr[ADDR_W-1 -: 2]);
  assign new_idx    = {bus_addr[ADDR_W-1 -: 2], bus_addr[OFF_W +: WORD_BITS]};

  assign waiting   = dphase_q && !ready_q;
  assign complete  = dphase_q && ready_q;
  assign start     = bus_sel && bus_trans[1] && bus_ready && !waiting;
  assign busy_next = complete ? wr_q : busy_q;
  assign last_wait = waiting && (cnt_q == CNT_W'(1));

  ws_latency #(
    .W_FAST(W_FAST), .W_FIXED(W_FIXED),
    .W_VAR_SHORT(W_VAR_SHORT), .W_VAR_LONG(W_VAR_LONG), .CNT_W(CNT_W)
  ) u_latency (
    .region(new_region), .busy(busy_next), .waits(new_waits)
  );

  ws_lane_mask #(.LANES(LANES), .OFF_W(OFF_W)) u_mask (
    .off(bus_addr[OFF_W-1:0]), .size(bus_size), .mask(new_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dphase_q <= 1'b0;
      ready_q  <= 1'b1;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
      mask_q   <= '0;
    end else begin
      busy_q <= busy_next;
      if (waiting) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) ready_q <= 1'b1;
      end else if (start) begin
        dphase_q <= 1'b1;
        cnt_q    <= new_waits;
        ready_q  <= (new_waits == '0);
        wr_q     <= bus_write;
        idx_q    <= new_idx;
        mask_q   <= new_mask;
      end else begin
        dphase_q <= 1'b0;
        ready_q  <= 1'b1;
      end
    end
  end

  assign st_we   = complete && wr_q;
  assign st_rd   = (start && !bus_write && (new_waits == '0)) || (last_wait && !wr_q);
  assign st_ridx = waiting ? idx_q : new_idx;

  ws_store #(.LANES(LANES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .we(st_we), .widx(idx_q), .wmask(mask_q), .wdata(bus_wdata),
    .rd_en(st_rd), .ridx(st_ridx), .rdata(bus_rdata)
  );

  assign bus_ready_out = ready_q;
  assign bus_resp      = RESP_OKAY;
  assign unused_bits   = ^{bus_addr, bus_trans[0]};
endmodule

// File: rtl/ws_checker.sv
`timescale 1ns/1ps
module ws_checker #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int W_FAST      = 0,
  parameter int W_FIXED     = 3,
  parameter int W_VAR_SHORT = 1,
  parameter int W_VAR_LONG  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_trans,
  input logic              bus_ready,
  input logic              bus_ready_out,
  input logic [DATA_W-1:0] bus_rdata
);
  localparam int MAX_A    = (W_FAST > W_FIXED) ? W_FAST : W_FIXED;
  localparam int MAX_B    = (W_VAR_SHORT > W_VAR_LONG) ? W_VAR_SHORT : W_VAR_LONG;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;

  logic       taken;
  logic [1:0] rg;
  logic [15:0] low_run;
  logic unused_ck;

  assign taken = bus_sel && bus_trans[1] && bus_ready && bus_ready_out;
  assign rg    = bus_addr[ADDR_W-1 -: 2];
  assign unused_ck = ^bus_addr;

  always_ff @(posedge clk) begin
    if (rst)                low_run <= '0;
    else if (!bus_ready_out) low_run <= low_run + 16'd1;
    else                     low_run <= '0;
  end

  assert_idle_stays_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_ready_out && !taken) |=> bus_ready_out);

  assert_fast_zero_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (taken && (W_FAST == 0) && (rg == 2'd0 || rg == 2'd3)) |=> bus_ready_out);

  assert_fixed_stalls_R5: assert property (@(posedge clk) disable iff (rst)
    (taken && (W_FIXED > 0) && rg == 2'd1) |=> !bus_ready_out);

  assert_rdata_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_ready_out |-> (bus_rdata == '0));

  assert_wait_bounded_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_ready_out |-> (32'(low_run) < MAX_WAIT));
endmodule

bind waitstate_sub ws_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .W_FAST(W_FAST), .W_FIXED(W_FIXED),
  .W_VAR_SHORT(W_VAR_SHORT), .W_VAR_LONG(W_VAR_LONG)
) u_ws_checker (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
  .bus_trans(bus_trans), .bus_ready(bus_ready),
  .bus_ready_out(bus_ready_out), .bus_rdata(bus_rdata)
);

// File: tb/test_waitstate_sub.sv
`timescale 1ns/1ps
module test_waitstate_sub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  trans = 2'd0;
  logic        wr = 1'b0;
  logic [2:0]  size = 3'd2;
  logic [31:0] wdata = '0;
  logic        force_low = 1'b0;
  logic        bus_ready;
  logic        ready_out;
  logic [31:0] rdata;
  logic        resp;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [64];
  logic        mbusy = 1'b0;

  always #4 clk = ~clk;
  assign bus_ready = ready_out && !force_low;

  waitstate_sub i_waitstate_sub (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_addr(addr), .bus_trans(trans),
    .bus_write(wr), .bus_size(size), .bus_wdata(wdata), .bus_ready(bus_ready),
    .bus_ready_out(ready_out), .bus_rdata(rdata), .bus_resp(resp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int f_idx(input logic [11:0] a);
    return int'({a[11:10], a[5:2]});
  endfunction

  function automatic int f_waits(input logic [11:0] a, input logic b);
    case (a[11:10])
      2'd1:    return 3;
      2'd2:    return b ? 4 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic string f_tag(input logic [11:0] a);
    case (a[11:10])
      2'd1:    return "R5";
      2'd2:    return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [31:0] f_merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [1:0] off, input logic [2:0] sz);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) begin
      bit hit;
      if (sz >= 3'd2)      hit = 1'b1;
      else if (sz == 3'd1) hit = (l[1] == off[1]);
      else                 hit = (l[1:0] == off);
      if (hit) r[l*8 +: 8] = d[l*8 +: 8];
    end
    return r;
  endfunction

  task automatic xfer(input logic w, input logic [11:0] a, input logic [2:0] sz,
                      input logic [31:0] d);
    int  waits = 0;
    int  exp_w;
    bit  done = 1'b0;
    exp_w = f_waits(a, mbusy);
    @(negedge clk);
    sel = 1'b1; trans = 2'd2; wr = w; addr = a; size = sz;
    @(posedge clk);
    while (!done) begin
      @(negedge clk);
      sel = 1'b0; trans = 2'd0;
      if (ready_out) begin
        wdata = d;
        done = 1'b1;
      end else begin
        waits++;
        chk(rdata == 32'd0, "R7", "rdata during wait", rdata, 32'd0);
        wdata = ~d ^ 32'hA5C3_0F96;   // scrambled, must not be stored (R8)
        if (waits > 8) done = 1'b1;
      end
    end
    chk(waits == exp_w, f_tag(a), "wait count", 32'(waits), 32'(exp_w));
    chk(waits <= 4, "R12", "wait bound", 32'(waits), 32'd4);
    if (w) chk(rdata == 32'd0, "R7", "rdata on write completion", rdata, 32'd0);
    else   chk(rdata == mdl[f_idx(a)], "R8", "read data", rdata, mdl[f_idx(a)]);
    chk(resp == 1'b0, "R11", "response", 32'(resp), 32'd0);
    @(posedge clk);
    if (w) mdl[f_idx(a)] = f_merge(mdl[f_idx(a)], d, a[1:0], sz);
    mbusy = w;
  endtask

  // offer a write that must not be taken, then confirm no stall
  task automatic offer_ignored(input logic s, input logic [1:0] t, input logic fl,
                               input string what);
    @(negedge clk);
    sel = s; trans = t; wr = 1'b1; addr = 12'h404; size = 3'd2; force_low = fl;
    wdata = 32'hDEAD_BEEF;
    @(posedge clk);
    @(negedge clk);
    chk(ready_out == 1'b1, "R3", what, 32'(ready_out), 32'd1);
    chk(rdata == 32'd0, "R2", what, rdata, 32'd0);
    sel = 1'b0; trans = 2'd0; force_low = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready_out == 1'b1, "R1", "reset ready", 32'(ready_out), 32'd1);
    chk(rdata == 32'd0, "R1", "reset rdata", rdata, 32'd0);
    chk(resp == 1'b0, "R1", "reset resp", 32'(resp), 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk(ready_out == 1'b1, "R2", "idle ready", 32'(ready_out), 32'd1);
    end

    // preload every word with full-word writes
    for (int i = 0; i < 64; i++) begin
      logic [5:0] ii = 6'(i);
      mdl[i] = '0;
      xfer(1'b1, {ii[5:4], 4'b0000, ii[3:0], 2'b00}, 3'd2, $urandom);
    end

    // R6 directed: read after read is short, read after write is long
    xfer(1'b0, 12'h808, 3'd2, 32'd0);
    xfer(1'b0, 12'h80C, 3'd2, 32'd0);
    xfer(1'b1, 12'h810, 3'd2, 32'h1357_9BDF);
    xfer(1'b0, 12'h810, 3'd2, 32'd0);
    xfer(1'b0, 12'h810, 3'd2, 32'd0);

    // R13: bits 9:6 ignored, aliasing word in region 0
    xfer(1'b1, 12'h004, 3'd2, 32'hCAFE_0013);
    xfer(1'b0, 12'h3C4, 3'd2, 32'd0);

    // R9 directed: byte at lane 2, halfword at upper half
    xfer(1'b1, 12'h020, 3'd2, 32'h1122_3344);
    xfer(1'b1, 12'h022, 3'd0, 32'h00AB_0000);
    xfer(1'b0, 12'h020, 3'd2, 32'd0);
    chk(mdl[8] == 32'h11AB_3344, "R9", "byte lane model", mdl[8], 32'h11AB_3344);
    xfer(1'b1, 12'h422, 3'd1, 32'h7788_0000);
    xfer(1'b0, 12'h420, 3'd2, 32'd0);

    // R3 / R2: offers that must be ignored, then read the word back
    xfer(1'b0, 12'h404, 3'd2, 32'd0);
    offer_ignored(1'b1, 2'd2, 1'b1, "ready low offer");
    offer_ignored(1'b0, 2'd2, 1'b0, "deselected offer");
    offer_ignored(1'b1, 2'd1, 1'b0, "BUSY cycle");
    offer_ignored(1'b1, 2'd0, 1'b0, "IDLE cycle");
    xfer(1'b0, 12'h404, 3'd2, 32'd0);

    // R10: read issued in the completing cycle of a write to the same word
    @(negedge clk);
    sel = 1'b1; trans = 2'd2; wr = 1'b1; addr = 12'h030; size = 3'd2;
    @(posedge clk);
    @(negedge clk);
    chk(ready_out == 1'b1, "R4", "fast write completes", 32'(ready_out), 32'd1);
    wdata = 32'h600D_F00D;
    wr = 1'b0; trans = 2'd3; addr = 12'h030;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; trans = 2'd0;
    chk(ready_out == 1'b1, "R10", "bypass ready", 32'(ready_out), 32'd1);
    chk(rdata == 32'h600D_F00D, "R10", "bypass data", rdata, 32'h600D_F00D);
    @(posedge clk);
    mdl[12] = 32'h600D_F00D;
    mbusy = 1'b0;

    // R6: variable-region address phase during a write's completing cycle
    @(negedge clk);
    sel = 1'b1; trans = 2'd2; wr = 1'b1; addr = 12'h034; size = 3'd2;
    @(posedge clk);
    @(negedge clk);
    wdata = 32'h0BAD_CAB1;
    wr = 1'b0; addr = 12'h834;
    @(posedge clk);
    mdl[13] = 32'h0BAD_CAB1;
    begin
      int lows = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        sel = 1'b0; trans = 2'd0;
        if (ready_out) break;
        lows++;
      end
      chk(lows == 4, "R6", "wait after overlapped write", 32'(lows), 32'd4);
      chk(rdata == mdl[f_idx(12'h834)], "R8", "overlapped read data",
          rdata, mdl[f_idx(12'h834)]);
      @(posedge clk);
      mbusy = 1'b0;
    end

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [1:0]  rg   = 2'($urandom_range(0, 3));
      logic [3:0]  hi   = 4'($urandom);
      logic [3:0]  wd   = 4'($urandom);
      logic [2:0]  sz   = 3'($urandom_range(0, 2));
      logic [1:0]  off  = 2'($urandom);
      logic        w    = 1'($urandom);
      if (sz == 3'd1) off[0] = 1'b0;
      if (sz == 3'd2) off = 2'b00;
      xfer(w, {rg, hi, wd, off}, sz, $urandom);
    end

    @(negedge clk);
    chk(ready_out == 1'b1, "R2", "final idle ready", 32'(ready_out), 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule